// File: doc/BRIEF.md
# Pixel-to-Double-Rate Half-Symbol Gearbox

The block sits between a per-lane symbol encoder and a 5:1 output serializer. Once per pixel clock it takes one 10-bit encoded symbol for each of three lanes, as a 30-bit word. On a clock at exactly twice the pixel rate it hands the serializer a 15-bit word that holds one 5-bit half of every lane's symbol. The two clocks come from the same PLL and are phase-aligned, so every second rising edge of the double-rate clock coincides with a pixel-clock edge. Both clocks are used single data rate.

Inside the pixel domain, a capture register holds the current word and a framing bit flips on every pixel edge. The double-rate domain compares that bit with its own copy. A difference marks the double-rate edge in the middle of a pixel period. On that edge the lower halves go out and the upper halves are stored. On the following edge the stored upper halves go out. Lower-first matches the least-significant-bit-first order of the serial line. A lock input held low, or the asynchronous reset, forces the output to zero and re-arms the framing, so the first word after recovery again comes out lower half first.

Top module: `tmds_gearbox_10to5`

## Requirements
- R1: A word sampled on the pixel edge that coincides with double-rate edge n appears on `half_o` as its lower halves after double-rate edge n+1. Those are bits [4:0] of each 10-bit lane symbol.
- R2: The upper halves of the same word (bits [9:5] of each lane) appear after double-rate edge n+2 and stay until edge n+3.
- R3: Lane k takes input bits [10k+9:10k] and drives output bits [5k+4:5k]. Lane 0 sits at the least significant end, and no lane's data reaches another lane's output bits.
- R4: While lock is held high, every pixel period yields exactly one lower-half slot and then one upper-half slot, back to back with no gap. Pairing consecutive output slots rebuilds the input word sequence in order.
- R5: While `lock_i` is low, `half_o` is zero from the next double-rate edge on, and the captured word and the stored upper halves are cleared.
- R6: After `lock_i` rises, the first word captured on a pixel edge with lock high comes out lower half first with the R1/R2 latency. Until then the output stays zero and carries no data from before the loss of lock.
- R7: `rst_ni` low clears `half_o` to zero at once, without waiting for a clock edge, and resets the framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_px_i | input | 1 | Pixel clock |
| clk_2x_i | input | 1 | Double-rate clock, phase-aligned to clk_px_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | High when the clock source is locked; low holds the block idle |
| sym_i | input | 30 | Three 10-bit encoded symbols, lane 0 in the low bits |
| half_o | output | 15 | Three 5-bit half-symbols, lane 0 in the low bits |

## Verification
The bench targets the phase of the framing. If the two halves were swapped, or the mid-period edge were found one edge late, the rebuilt words would come back with their halves exchanged or paired across two pixel periods. A directed word with only one lane non-zero exposes a mis-sliced lane map as data in the wrong output bits. Loss of lock in mid-stream and its return check that no stale upper half leaks out and that the first new word keeps lower-first order at the stated latency. An asynchronous reset asserted between edges checks that the output clears without a clock.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  parameter int unsigned GBX_LANES = 3;
  parameter int unsigned GBX_SYM_W = 10;
endpackage

// File: rtl/gbx_px_capture.sv
module gbx_px_capture #(
  parameter int unsigned IN_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic [IN_W-1:0] sym_i,
  output logic [IN_W-1:0] cap_o,
  output logic            tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o <= '0;
      tog_o <= 1'b0;
    end else if (!lock_i) begin
      cap_o <= '0;
      tog_o <= 1'b0;
    end else begin
      cap_o <= sym_i;
      tog_o <= ~tog_o;
    end
  end
endmodule

// File: rtl/gbx_frame_detect.sv
module gbx_frame_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic tog_i,
  output logic lo_slot_o
);
  logic tog_s;

  // tog_i only moves on pixel edges; a change seen here marks the mid-period edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_s <= 1'b0;
    else if (!lock_i) tog_s <= 1'b0;
    else              tog_s <= tog_i;
  end

  assign lo_slot_o = tog_i ^ tog_s;
endmodule

// File: rtl/gbx_half_mux.sv
module gbx_half_mux #(
  parameter int unsigned LANES = 3,
  parameter int unsigned SYM_W = 10,
  localparam int unsigned HALF_W = SYM_W / 2,
  localparam int unsigned IN_W = LANES * SYM_W,
  localparam int unsigned OUT_W = LANES * HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             lo_slot_i,
  input  logic [IN_W-1:0]  cap_i,
  output logic [OUT_W-1:0] half_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [HALF_W-1:0] hi_q;
    logic [HALF_W-1:0] out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q  <= '0;
        out_q <= '0;
      end else if (!lock_i) begin
        hi_q  <= '0;
        out_q <= '0;
      end else if (lo_slot_i) begin
        out_q <= cap_i[l*SYM_W +: HALF_W];
        hi_q  <= cap_i[l*SYM_W+HALF_W +: HALF_W];
      end else begin
        out_q <= hi_q;
      end
    end

    assign half_o[l*HALF_W +: HALF_W] = out_q;
  end
endmodule

// File: rtl/tmds_gearbox_10to5.sv
module tmds_gearbox_10to5 #(
  parameter int unsigned LANES = gbx_pkg::GBX_LANES,
  parameter int unsigned SYM_W = gbx_pkg::GBX_SYM_W,
  localparam int unsigned HALF_W = SYM_W / 2,
  localparam int unsigned IN_W = LANES * SYM_W,
  localparam int unsigned OUT_W = LANES * HALF_W
) (
  input  logic             clk_px_i,
  input  logic             clk_2x_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic [IN_W-1:0]  sym_i,
  output logic [OUT_W-1:0] half_o
);
  logic [IN_W-1:0] cap;
  logic            tog;
  logic            lo_slot;

  gbx_px_capture #(.IN_W(IN_W)) u_cap (
    .clk_i (clk_px_i),
    .rst_ni(rst_ni),
    .lock_i(lock_i),
    .sym_i (sym_i),
    .cap_o (cap),
    .tog_o (tog)
  );

  gbx_frame_detect u_frame (
    .clk_i    (clk_2x_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .tog_i    (tog),
    .lo_slot_o(lo_slot)
  );

  gbx_half_mux #(.LANES(LANES), .SYM_W(SYM_W)) u_mux (
    .clk_i    (clk_2x_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .lo_slot_i(lo_slot),
    .cap_i    (cap),
    .half_o   (half_o)
  );
endmodule

// File: rtl/tmds_gearbox_10to5_chk.sv
module tmds_gearbox_10to5_chk #(
  parameter int unsigned LANES = 3,
  parameter int unsigned SYM_W = 10,
  localparam int unsigned HALF_W = SYM_W / 2,
  localparam int unsigned IN_W = LANES * SYM_W,
  localparam int unsigned OUT_W = LANES * HALF_W
) (
  input logic             clk_2x_i,
  input logic             rst_ni,
  input logic             lock_i,
  input logic             lo_slot,
  input logic [IN_W-1:0]  sym_i,
  input logic [OUT_W-1:0] half_o
);
  logic [2:0] settle_q;

  always_ff @(posedge clk_2x_i or negedge rst_ni) begin
    if (!rst_ni)            settle_q <= '0;
    else if (!lock_i)       settle_q <= '0;
    else if (settle_q != 3'd7) settle_q <= settle_q + 3'd1;
  end

  // R4: mid-period slots alternate once framing has settled
  a_r4_slot_alternates: assert property (@(posedge clk_2x_i) disable iff (!rst_ni)
    (settle_q >= 3'd3) |-> (lo_slot != $past(lo_slot)));

  // R5: lock low clears the output on the next edge
  a_r5_lock_zero: assert property (@(posedge clk_2x_i) disable iff (!rst_ni)
    !lock_i |=> (half_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R1: lower half of the word sampled two edges back
    a_r1_low_half: assert property (@(posedge clk_2x_i) disable iff (!rst_ni)
      (settle_q >= 3'd3 && $past(lo_slot)) |->
      (half_o[l*HALF_W +: HALF_W] == $past(sym_i[l*SYM_W +: HALF_W], 2)));
    // R2: upper half of the word sampled three edges back
    a_r2_high_half: assert property (@(posedge clk_2x_i) disable iff (!rst_ni)
      (settle_q >= 3'd4 && $past(lo_slot, 2)) |->
      (half_o[l*HALF_W +: HALF_W] == $past(sym_i[l*SYM_W+HALF_W +: HALF_W], 3)));
  end
endmodule

bind tmds_gearbox_10to5 tmds_gearbox_10to5_chk #(.LANES(LANES), .SYM_W(SYM_W)) u_chk (
  .clk_2x_i(clk_2x_i),
  .rst_ni  (rst_ni),
  .lock_i  (lock_i),
  .lo_slot (lo_slot),
  .sym_i   (sym_i),
  .half_o  (half_o)
);

// File: tb/tmds_gearbox_10to5_bench.sv
`timescale 1ns/1ps
module tmds_gearbox_10to5_bench;
  localparam int LN = 3;
  localparam int SW = 10;
  localparam int HW = 5;

  logic clk_2x = 1'b0;
  logic clk_px = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0;
  logic [LN*SW-1:0] sym = '0;
  logic [LN*HW-1:0] half;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  tmds_gearbox_10to5 u_tmds_gearbox_10to5 (
    .clk_px_i(clk_px), .clk_2x_i(clk_2x), .rst_ni(rst_n),
    .lock_i(lock), .sym_i(sym), .half_o(half)
  );

  initial forever #2.5 clk_2x = ~clk_2x;
  always @(posedge clk_2x) clk_px <= ~clk_px;

  function automatic logic [LN*HW-1:0] lo_of(input logic [LN*SW-1:0] w);
    logic [LN*HW-1:0] r;
    for (int l = 0; l < LN; l++) for (int b = 0; b < HW; b++) r[l*HW+b] = w[l*SW+b];
    return r;
  endfunction
  function automatic logic [LN*HW-1:0] hi_of(input logic [LN*SW-1:0] w);
    logic [LN*HW-1:0] r;
    for (int l = 0; l < LN; l++) for (int b = 0; b < HW; b++) r[l*HW+b] = w[l*SW+HW+b];
    return r;
  endfunction

  task automatic check(input string req, input logic [LN*HW-1:0] act, input logic [LN*HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: the word held for this pixel period and the pending upper halves
  logic [LN*SW-1:0] m_word = '0;
  logic [LN*HW-1:0] m_up = '0;
  logic [LN*HW-1:0] m_exp = '0;
  string m_tag = "R7";
  bit rb_en = 0;
  logic [LN*SW-1:0] sent_q[$];

  always @(posedge clk_2x) begin
    if (!rst_n) begin
      m_word = '0; m_up = '0; m_exp = '0; m_tag = "R7";
    end else if (!lock) begin
      m_exp = '0; m_up = '0; m_tag = "R5";
      if (!clk_px) m_word = '0;
    end else if (!clk_px) begin
      m_exp = m_up; m_tag = "R2";
      m_word = sym;
      if (rb_en) sent_q.push_back(sym);
    end else begin
      m_exp = lo_of(m_word); m_up = hi_of(m_word); m_tag = "R1";
    end
  end

  logic [LN*HW-1:0] rb_lo = '0;
  bit rb_have = 0;
  always @(negedge clk_2x) begin
    if (!done) begin
      check(m_tag, half, m_exp);
      if (!rb_en) begin
        rb_have = 0;
      end else if (!clk_px) begin
        if (sent_q.size() > 0) begin rb_lo = half; rb_have = 1; end
      end else if (rb_have) begin
        logic [LN*SW-1:0] w;
        w = sent_q.pop_front();
        check("R4 rebuild lo", rb_lo, lo_of(w));
        check("R4 rebuild hi", half, hi_of(w));
        rb_have = 0;
      end
    end
  end

  task automatic send(input logic [LN*SW-1:0] w);
    @(posedge clk_px); @(negedge clk_2x); sym = w;
  endtask
  task automatic set_lock(input logic v);
    @(posedge clk_px); @(negedge clk_2x); lock = v;
  endtask
  // Word is captured on the next pixel edge; look at the two slots after it
  task automatic directed(input logic [LN*SW-1:0] w, input string tag);
    send(w);
    @(posedge clk_px); @(negedge clk_2x);
    @(negedge clk_2x); check({tag, " R1 low"}, half, lo_of(w));
    @(negedge clk_2x); check({tag, " R2 high"}, half, hi_of(w));
  endtask

  task automatic run_random(input int n);
    sent_q.delete(); rb_en = 1;
    for (int i = 0; i < n; i++) send($urandom());
    repeat (3) @(posedge clk_px);
    @(negedge clk_2x); rb_en = 0; sent_q.delete();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #13; check("R7 reset", half, '0);
    #10; rst_n = 1'b1;
    set_lock(1'b1);
    run_random(40);
    // R3: single-lane patterns stay in their own output bits
    directed(30'h0000_03FF, "R3 lane0");
    directed(30'h000F_FC00, "R3 lane1");
    directed(30'h3FF0_0000, "R3 lane2");
    directed(30'h2AA5_5A5A, "R3 mixed");
    // R5: loss of lock in mid-stream
    send(30'h1234_5678);
    set_lock(1'b0);
    repeat (6) begin @(negedge clk_2x); check("R5 lock low", half, '0); end
    // R6: recovery with a known word waiting
    sym = 30'h1ABC_DEF1;
    set_lock(1'b1);
    @(posedge clk_px); @(negedge clk_2x); check("R6 idle before first word", half, '0);
    @(negedge clk_2x); check("R6 first low", half, lo_of(30'h1ABC_DEF1));
    @(negedge clk_2x); check("R6 first high", half, hi_of(30'h1ABC_DEF1));
    run_random(20);
    // R7: asynchronous reset between edges
    @(negedge clk_2x); #1 rst_n = 1'b0;
    #0.5 check("R7 async clear", half, '0);
    @(negedge clk_2x); #1 rst_n = 1'b1;
    run_random(30);
    directed(30'h3FFF_FFFF, "R4 all ones");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule